// File: doc/BRIEF.md
# Four-Channel Synthesizer Configuration Slave

This block is the serial configuration port of a four-channel signal synthesizer core. A host shifts in an instruction byte followed by a data word whose length depends on the address. The block keeps three global registers once and a bank of per-channel registers for each of four channels. A channel-register write is not aimed at one channel. It is copied into every channel whose enable bit is set in the first global register, so a single transaction can program several channels at once.

Writes to the second and third global registers and to all channel registers go into shadow storage. The synthesis datapath reads an active copy through a small combinational lookup port (`actCh`, `actAddr`, `actData`). The whole shadow set is copied into the active set only when the host pulses `ioUpdate`. The first global register holds the channel enables, the wire mode and the bit order. It takes effect as soon as its write completes, because it steers how the very next transaction is framed and routed.

The serial lines are sampled with the fast system clock. Each one passes through a two-stage synchronizer, so `clk` must run at least eight times faster than `sclk`. In two-wire mode, read data goes out on the shared data pin, shown here as `sdioIn`/`sdioOut`/`sdioOe`. In three-wire mode, read data goes out on a dedicated output pin, `sdoOut`.

Top module: `synth_cfg_slave`

## Requirements
- R1: After reset, global register 0 is 0x00, which means MSB-first order, two-wire mode and no channel enabled. Every shadow and active register reads zero, and `sdioOe` and `sdoOut` are low.
- R2: A transaction starts with an 8-bit instruction. Bit 7 = 1 means read and 0 means write. Bits 4:0 are the register address. Bits 6:5 are ignored.
- R3: The data length follows the address. Address 0 is 8 bits. Addresses 1, 2, 3 and 6 are 24 bits. Addresses 4 (frequency), 5 (phase offset) and 7 to 0x18 are 32 bits. Addresses 0x19 to 0x1F take 32 bits, drop writes and read as zero.
- R4: A write to address 0x03 to 0x18 goes to every channel n (0 to 3) for which bit 4+n of register 0 is set. Several channels can be written at once.
- R5: When no enable bit is set, a channel-register write changes nothing.
- R6: Registers 1 and 2 are written and read regardless of the channel enables.
- R7: Writes to registers 1 to 0x18 change only the shadow copy. The active copy seen on `actData` keeps its old value until `ioUpdate` is high for a clock. One clock later, every active register equals its shadow.
- R8: Register 0 bit 0 selects LSB-first order (1) and bit 1 selects three-wire mode (1). Register 0 changes only when its own write completes. It needs no `ioUpdate` pulse and applies from the next instruction onward.
- R9: In LSB-first order, both the instruction and the data word are sent least significant bit first. This reverses the bit order and the byte order together. In MSB-first order, the most significant bit goes first.
- R10: Input bits are taken on the rising edge of `sclk`, which idles low. A change on `sdioIn` while `sclk` is high has no effect. Read data changes after a falling edge and is valid at the next rising edge.
- R11: In a two-wire read, `sdioOe` is high during the data phase, the data appears on `sdioOut`, and `sdoOut` stays low. In three-wire mode, the data appears on `sdoOut` and `sdioOe` stays low.
- R12: Reading a channel register returns the shadow value of the lowest-numbered enabled channel. With no channel enabled, the read returns zero.
- R13: When `csN` goes high, any transaction in progress is cancelled, a partly shifted write is discarded, and the next transaction starts again at the instruction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| csN | input | 1 | Active-low chip select |
| sdioIn | input | 1 | Serial data from the host |
| sdioOut | output | 1 | Read data on the shared pin in two-wire mode |
| sdioOe | output | 1 | Drive enable for the shared pin |
| sdoOut | output | 1 | Read data pin in three-wire mode |
| ioUpdate | input | 1 | Strobe that copies all shadow registers to the active set |
| actCh | input | 2 | Channel selected on the active lookup port |
| actAddr | input | 5 | Address selected on the active lookup port |
| actData | output | 32 | Active value at the selected channel and address |

## Verification
The checker watches four properties on every cycle. The active value at a fixed lookup address never moves unless `ioUpdate` was high one cycle earlier. The mode bits change only on the cycle that completes a word. `sdioOe` never rises in three-wire mode and drops after a chip-select release. The internal strobes never coincide. Other behaviour can only be shown by the bench's scenarios: broadcast routing across all sixteen enable masks, lowest-channel readback, the width table, LSB-first framing, and cancellation of a partial write. In each of these the bench compares the value read back over the serial port or the active lookup port against its own model of the register bank.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int FIRST_CH  = 3;

  typedef struct packed {
    logic             idle;       // chip select released
    logic             sampleBit;  // write data bit taken this cycle
    logic             dataBit;
    logic [4:0]       bitIdx;
    logic             instrLast;  // last instruction bit taken
    logic             wordLast;   // last data bit of the word taken
    logic             isRead;
    logic [ADDR_W-1:0] addr;
    logic             fallOut;    // shift out next read bit
    logic [4:0]       outIdx;
  } strobe_t;

  function automatic logic [5:0] regBits(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0:                         regBits = 6'd8;
      5'd1, 5'd2, 5'd3, 5'd6:       regBits = 6'd24;
      default:                      regBits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/synth_cfg_ctrl.sv
`timescale 1ns/1ps
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    sdioIn,
  input  logic    cfgLsb,
  output strobe_t strb
);
  logic [2:0] sclkSh;
  logic [1:0] csSh, dinSh;
  logic rise, fall, csHigh, din;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSh <= '0;
      csSh   <= 2'b11;
      dinSh  <= '0;
    end else begin
      sclkSh <= {sclkSh[1:0], sclk};
      csSh   <= {csSh[0], csN};
      dinSh  <= {dinSh[0], sdioIn};
    end
  end

  assign rise   = sclkSh[1] & ~sclkSh[2];
  assign fall   = ~sclkSh[1] & sclkSh[2];
  assign csHigh = csSh[1];
  assign din    = dinSh[1];

  logic              inData, isRead;
  logic [ADDR_W-1:0] addr;
  logic [5:0]        nbits, bitCnt, outCnt;
  logic [7:0]        instr, instrNext;
  logic [2:0]        instrPos;
  logic              lastInstr, lastData, outMore;

  always_comb begin
    instrPos  = cfgLsb ? bitCnt[2:0] : 3'd7 - bitCnt[2:0];
    instrNext = instr;
    instrNext[instrPos] = din;
    lastInstr = rise & ~csHigh & ~inData & (bitCnt == 6'd7);
    lastData  = rise & ~csHigh & inData & (bitCnt == nbits - 6'd1);
    outMore   = fall & ~csHigh & inData & isRead & (outCnt < nbits);

    strb           = '0;
    strb.idle      = csHigh;
    strb.sampleBit = rise & ~csHigh & inData & ~isRead;
    strb.dataBit   = din;
    strb.bitIdx    = cfgLsb ? bitCnt[4:0] : 5'(nbits - 6'd1 - bitCnt);
    strb.instrLast = lastInstr;
    strb.wordLast  = lastData;
    strb.isRead    = inData ? isRead : instrNext[7];
    strb.addr      = inData ? addr : instrNext[ADDR_W-1:0];
    strb.fallOut   = outMore;
    strb.outIdx    = cfgLsb ? outCnt[4:0] : 5'(nbits - 6'd1 - outCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN || csHigh) begin
      inData <= 1'b0;
      isRead <= 1'b0;
      addr   <= '0;
      nbits  <= 6'd8;
      bitCnt <= '0;
      outCnt <= '0;
      instr  <= '0;
    end else begin
      if (rise) begin
        if (!inData) begin
          instr <= instrNext;
          if (lastInstr) begin
            inData <= 1'b1;
            bitCnt <= '0;
            outCnt <= '0;
            isRead <= instrNext[7];
            addr   <= instrNext[ADDR_W-1:0];
            nbits  <= regBits(instrNext[ADDR_W-1:0]);
          end else begin
            bitCnt <= bitCnt + 6'd1;
          end
        end else if (lastData) begin
          inData <= 1'b0;
          bitCnt <= '0;
          instr  <= '0;
        end else begin
          bitCnt <= bitCnt + 6'd1;
        end
      end
      if (outMore) outCnt <= outCnt + 6'd1;
    end
  end
endmodule

// File: rtl/synth_cfg_regs.sv
`timescale 1ns/1ps
module synth_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CH_REGS = 22,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int IDX_W  = $clog2(CH_REGS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              ioUpdate,
  input  logic [CH_W-1:0]   actCh,
  input  logic [ADDR_W-1:0] actAddr,
  output logic [WORD_W-1:0] actData,
  output logic              cfgLsb,
  output logic              cfgThree,
  output logic              sdioOut,
  output logic              sdioOe,
  output logic              sdoOut
);
  localparam int LAST_CH = FIRST_CH + CH_REGS;

  logic [7:0]        reg0;
  logic [23:0]       g1Sh, g2Sh, g1Act, g2Act;
  logic [WORD_W-1:0] chSh  [NUM_CH][CH_REGS];
  logic [WORD_W-1:0] chAct [NUM_CH][CH_REGS];
  logic [WORD_W-1:0] shReg, wordVal, readVal, readWord;
  logic              outBit;

  assign cfgLsb   = reg0[0];
  assign cfgThree = reg0[1];

  function automatic logic inChRange(input logic [ADDR_W-1:0] a);
    return (int'(a) >= FIRST_CH) && (int'(a) < LAST_CH);
  endfunction

  function automatic logic [IDX_W-1:0] relIdx(input logic [ADDR_W-1:0] a);
    return IDX_W'(a - ADDR_W'(FIRST_CH));
  endfunction

  assign wordVal = shReg | (WORD_W'(strb.dataBit) << strb.bitIdx);

  always_comb begin
    readVal = '0;
    if (strb.addr == 5'd0)      readVal = WORD_W'(reg0);
    else if (strb.addr == 5'd1) readVal = WORD_W'(g1Sh);
    else if (strb.addr == 5'd2) readVal = WORD_W'(g2Sh);
    else if (inChRange(strb.addr)) begin
      for (int c = NUM_CH - 1; c >= 0; c--)
        if (reg0[4 + c]) readVal = chSh[c][relIdx(strb.addr)];
    end
  end

  always_comb begin
    actData = '0;
    if (actAddr == 5'd0)      actData = WORD_W'(reg0);
    else if (actAddr == 5'd1) actData = WORD_W'(g1Act);
    else if (actAddr == 5'd2) actData = WORD_W'(g2Act);
    else if (inChRange(actAddr)) actData = chAct[actCh][relIdx(actAddr)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reg0 <= '0;
      g1Sh <= '0; g2Sh <= '0; g1Act <= '0; g2Act <= '0;
      for (int c = 0; c < NUM_CH; c++)
        for (int r = 0; r < CH_REGS; r++) begin
          chSh[c][r]  <= '0;
          chAct[c][r] <= '0;
        end
    end else begin
      if (ioUpdate) begin
        g1Act <= g1Sh;
        g2Act <= g2Sh;
        chAct <= chSh;
      end
      if (strb.wordLast && !strb.isRead) begin
        if (strb.addr == 5'd0)      reg0 <= wordVal[7:0];
        else if (strb.addr == 5'd1) g1Sh <= wordVal[23:0];
        else if (strb.addr == 5'd2) g2Sh <= wordVal[23:0];
        else if (inChRange(strb.addr)) begin
          for (int c = 0; c < NUM_CH; c++)
            if (reg0[4 + c]) chSh[c][relIdx(strb.addr)] <= wordVal;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.idle) begin
      shReg    <= '0;
      readWord <= '0;
      outBit   <= 1'b0;
      sdioOe   <= 1'b0;
    end else begin
      if (strb.instrLast) begin
        shReg    <= '0;
        readWord <= readVal;
        sdioOe   <= strb.isRead & ~cfgThree;
      end else if (strb.sampleBit) begin
        shReg[strb.bitIdx] <= strb.dataBit;
      end
      if (strb.wordLast) begin
        sdioOe <= 1'b0;
        outBit <= 1'b0;
      end else if (strb.fallOut) begin
        outBit <= readWord[strb.outIdx];
      end
    end
  end

  assign sdioOut = outBit & ~cfgThree;
  assign sdoOut  = outBit & cfgThree;
endmodule

// File: rtl/synth_cfg_slave.sv
`timescale 1ns/1ps
module synth_cfg_slave
  import synth_cfg_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CH_REGS = 22
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        sdioIn,
  output logic        sdioOut,
  output logic        sdioOe,
  output logic        sdoOut,
  input  logic        ioUpdate,
  input  logic [1:0]  actCh,
  input  logic [4:0]  actAddr,
  output logic [31:0] actData
);
  strobe_t strb;
  logic    cfgLsb, cfgThree;

  synth_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .cfgLsb(cfgLsb), .strb(strb)
  );

  synth_cfg_regs #(.NUM_CH(NUM_CH), .CH_REGS(CH_REGS)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .ioUpdate(ioUpdate),
    .actCh(actCh), .actAddr(actAddr), .actData(actData),
    .cfgLsb(cfgLsb), .cfgThree(cfgThree),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut)
  );
endmodule

// File: rtl/synth_cfg_chk.sv
`timescale 1ns/1ps
module synth_cfg_chk
  import synth_cfg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sdioOe,
  input logic        ioUpdate,
  input logic [1:0]  actCh,
  input logic [4:0]  actAddr,
  input logic [31:0] actData,
  input logic        cfgLsb,
  input logic        cfgThree,
  input strobe_t     strb
);
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ioUpdate) && actCh == $past(actCh) && actAddr == $past(actAddr) && actAddr != 5'd0)
      |-> actData == $past(actData)); // R7

  AST_CFG_ON_WORD_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wordLast) |-> (cfgLsb == $past(cfgLsb) && cfgThree == $past(cfgThree))); // R8

  AST_OE_TWO_WIRE: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> !cfgThree); // R11

  AST_RELEASE_DROPS_OE: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> !sdioOe); // R13

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.instrLast, strb.wordLast, strb.fallOut})); // R10
endmodule

bind synth_cfg_slave synth_cfg_chk chk_i (
  .clk(clk), .rstN(rstN), .sdioOe(sdioOe), .ioUpdate(ioUpdate),
  .actCh(actCh), .actAddr(actAddr), .actData(actData),
  .cfgLsb(cfgLsb), .cfgThree(cfgThree), .strb(strb)
);

// File: tb/synth_cfg_slave_tb.sv
`timescale 1ns/1ps
module synth_cfg_slave_tb_top;
  logic clk = 0, rstN = 0, sclk = 0, csN = 1, sdioIn = 0, ioUpdate = 0;
  logic [1:0]  actCh = 0;
  logic [4:0]  actAddr = 0;
  logic        sdioOut, sdioOe, sdoOut;
  logic [31:0] actData;

  always #2.5 clk = ~clk;

  synth_cfg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .ioUpdate(ioUpdate),
    .actCh(actCh), .actAddr(actAddr), .actData(actData)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit lsbMode = 0, threeMode = 0;
  logic [3:0]  enMask = 0;
  logic [31:0] shM [4][32];
  logic [31:0] actM[4][32];
  logic [31:0] g1M = 0, g2M = 0, g1A = 0, g2A = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bw(input logic [4:0] a);
    if (a == 0) return 8;
    if (a == 1 || a == 2 || a == 3 || a == 6) return 24;
    return 32;
  endfunction

  task automatic halfBit();
    repeat (8) @(negedge clk);
  endtask

  // stopAfter < 0: full transaction; else release chip select after that many data bits
  task automatic spiXfer(input bit rd, input logic [1:0] junk, input logic [4:0] a,
                         input logic [31:0] wd, input int stopAfter,
                         output logic [31:0] rdv, output bit oeAll, output bit oeAny,
                         output bit sdoAny);
    logic [7:0] ins;
    int n, nb;
    ins = {rd, junk, a};
    n = bw(a);
    nb = (stopAfter < 0) ? n : stopAfter;
    rdv = 0; oeAll = 1; oeAny = 0; sdoAny = 0;
    @(negedge clk); csN = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sdioIn = lsbMode ? ins[i] : ins[7 - i];
      halfBit(); sclk = 1;
      repeat (4) @(negedge clk); sdioIn = ~sdioIn;   // change while high must be ignored
      repeat (4) @(negedge clk); sclk = 0;
    end
    for (int i = 0; i < nb; i++) begin
      int idx;
      idx = lsbMode ? i : n - 1 - i;
      sdioIn = rd ? 1'b0 : wd[idx];
      halfBit();
      if (rd) begin
        rdv[idx] = threeMode ? sdoOut : sdioOut;
        oeAll &= sdioOe; oeAny |= sdioOe; sdoAny |= sdoOut;
      end
      sclk = 1;
      repeat (4) @(negedge clk); sdioIn = ~sdioIn;
      repeat (4) @(negedge clk); sclk = 0;
    end
    repeat (6) @(negedge clk); csN = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] wd);
    logic [31:0] r; bit x, y, z;
    spiXfer(0, 2'b00, a, wd, -1, r, x, y, z);
    if (a == 1) g1M = wd[23:0];
    else if (a == 2) g2M = wd[23:0];
    else if (a >= 3 && a <= 24)
      for (int c = 0; c < 4; c++) if (enMask[c]) shM[c][a] = wd;
  endtask

  task automatic setCfg(input logic [3:0] en, input bit three, input bit lsb);
    wr(5'd0, {en, 2'b00, three, lsb});
    enMask = en; threeMode = three; lsbMode = lsb;
  endtask

  function automatic logic [31:0] expRead(input logic [4:0] a);
    if (a == 0) return {24'd0, enMask, 2'b00, threeMode, lsbMode};
    if (a == 1) return g1M;
    if (a == 2) return g2M;
    if (a > 24) return 0;
    for (int c = 0; c < 4; c++) if (enMask[c]) return shM[c][a];
    return 0;
  endfunction

  task automatic pulseUpdate();
    @(negedge clk); ioUpdate = 1;
    @(negedge clk); ioUpdate = 0;
    g1A = g1M; g2A = g2M;
    for (int c = 0; c < 4; c++) for (int r = 0; r < 32; r++) actM[c][r] = shM[c][r];
  endtask

  task automatic checkActive(input string req, input logic [4:0] a);
    for (int c = 0; c < 4; c++) begin
      actCh = c[1:0]; actAddr = a;
      @(negedge clk);
      chk(req, actData, a == 1 ? g1A : a == 2 ? g2A : actM[c][a]);
    end
  endtask

  task automatic rdChk(input string req, input logic [4:0] a);
    logic [31:0] r; bit oeAll, oeAny, sdoAny;
    spiXfer(1, 2'b00, a, 0, -1, r, oeAll, oeAny, sdoAny);
    chk(req, r, expRead(a));
    if (threeMode) begin
      chk({req, " R11 oe low three-wire"}, 32'(oeAny), 0);
    end else begin
      chk({req, " R11 oe high two-wire"}, 32'(oeAll), 1);
      chk({req, " R11 sdo quiet two-wire"}, 32'(sdoAny), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r; bit x, y, z;
    for (int c = 0; c < 4; c++) for (int k = 0; k < 32; k++) begin shM[c][k] = 0; actM[c][k] = 0; end
    repeat (5) @(negedge clk); rstN = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 oe", 32'(sdioOe), 0);
    chk("R1 sdo", 32'(sdoOut), 0);
    actAddr = 0; @(negedge clk); chk("R1 reg0", actData, 0);
    checkActive("R1 active freq", 5'd4);
    rdChk("R1 read reg1", 5'd1);

    // R6 R3 globals with no channel enabled, R7 shadow vs active
    wr(5'd1, 32'h00ABCDEF);
    wr(5'd2, 32'h00135724);
    rdChk("R6 R3 reg1", 5'd1);
    rdChk("R6 reg2", 5'd2);
    checkActive("R7 reg1 held", 5'd1);
    pulseUpdate();
    checkActive("R7 reg1 applied", 5'd1);
    checkActive("R7 reg2 applied", 5'd2);

    // R5 no enable: channel write dropped
    wr(5'd4, 32'hDEADBEEF);
    setCfg(4'hF, 0, 0);
    rdChk("R5 dropped write", 5'd4);

    // R4 R12 R7 sweep all enable masks
    for (int m = 0; m < 16; m++) begin
      setCfg(m[3:0], 0, 0);
      actAddr = 0; @(negedge clk);
      chk("R8 reg0 immediate", actData, {24'd0, m[3:0], 4'd0});
      wr(5'd4, 32'h10000000 | (m * 32'h00010203));
      rdChk("R4 R12 broadcast read", 5'd4);
      checkActive("R7 held before update", 5'd4);
      pulseUpdate();
      checkActive("R4 R7 active after update", 5'd4);
    end

    // R12 readback of lowest enabled channel with differing contents
    setCfg(4'b0100, 0, 0); wr(5'd5, 32'hC0C0C0C2);
    setCfg(4'b1000, 0, 0); wr(5'd5, 32'hC0C0C0C3);
    setCfg(4'b1100, 0, 0); rdChk("R12 lowest is ch2", 5'd5);
    setCfg(4'b0000, 0, 0); rdChk("R12 none enabled", 5'd5);

    // R3 width table
    setCfg(4'b0001, 0, 0);
    wr(5'd3, 32'h00654321); rdChk("R3 24-bit reg3", 5'd3);
    wr(5'd6, 32'h00FEDCBA); rdChk("R3 24-bit reg6", 5'd6);
    wr(5'd24, 32'h89ABCDEF); rdChk("R3 32-bit last channel reg", 5'd24);
    wr(5'd26, 32'h55555555); rdChk("R3 unused address", 5'd26);
    rdChk("R3 neighbour intact", 5'd24);

    // R2 junk bits in instruction ignored
    spiXfer(1, 2'b11, 5'd24, 0, -1, r, x, y, z);
    chk("R2 bits 6:5 ignored", r, shM[0][24]);

    // R9 LSB-first
    setCfg(4'b0001, 0, 1);
    wr(5'd4, 32'h80000001 ^ 32'h00F0A500);
    rdChk("R9 LSB round trip", 5'd4);
    setCfg(4'b0001, 0, 0);
    rdChk("R9 value same in MSB order", 5'd4);

    // R11 three-wire
    setCfg(4'b0001, 1, 0);
    rdChk("R11 three-wire read", 5'd4);
    setCfg(4'b0001, 1, 1);
    rdChk("R11 R9 three-wire LSB", 5'd1);
    setCfg(4'b0001, 0, 0);

    // R13 abort mid write
    spiXfer(0, 2'b00, 5'd4, 32'hFFFFFFFF, 10, r, x, y, z);
    rdChk("R13 partial write discarded", 5'd4);
    spiXfer(0, 2'b00, 5'd1, 32'h00FFFFFF, 5, r, x, y, z);
    wr(5'd2, 32'h00A5A5A5);
    rdChk("R13 next transaction framed", 5'd2);
    rdChk("R13 reg1 intact", 5'd1);
    pulseUpdate();
    checkActive("R7 R13 final active", 5'd4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule